// File: doc/BRIEF.md
# Strobe-Captured Byte Serializer

This block takes bytes from a source that offers only an 8-bit data bus and a gated strobe. The strobe toggles only while a byte is present, and the source gives no valid or ready signal. On its active edge the strobe itself clocks the byte into a holding register and flips a one-bit flag. The flag is the only signal that crosses into the free-running local clock domain.

In the local domain the flag passes through a synchronizer chain of selectable depth and one more delay register. A change in the flag gives a registered pulse that lasts one local cycle. That pulse copies the held byte into a shift register. In every other cycle the register shifts left and pulls in zeros, and its top bit is the serial output. The same pulse appears on an output so the receiving side knows where each byte starts. Which strobe edge is active is fixed when the block is elaborated.

Top module: `strobe_byte_serializer`

## Requirements
- R1: On the active strobe edge the byte on `strb_data` is held and later sent out unchanged on `ser_out`, most significant bit first.
- R2: Parameter `CAP_EDGE` picks the active strobe edge: `EDGE_RISE` captures on the rising edge and `EDGE_FALL` on the falling edge.
- R3: Each strobe edge gives exactly one `byte_loaded` pulse, and that pulse is high for exactly one local clock cycle.
- R4: Count the first local rising edge after the strobe edge as edge 1. `byte_loaded` is high in the cycle after local edge `SYNC_STAGES`+1 and low before it.
- R5: In the cycle after the `byte_loaded` cycle, `ser_out` shows bit 7 of the byte. Each later cycle shows the next lower bit, down to bit 0.
- R6: The shift register fills with zeros, so `ser_out` is 0 once all eight bits have gone out and stays 0 until the next load.
- R7: A load overrides a shift that is still in progress. The new byte starts from its MSB right away, as long as strobe edges are more than `SYNC_STAGES`+3 local cycles apart.
- R8: While `rst` (synchronous, active high) is asserted, `ser_out` and `byte_loaded` are 0. After release, no pulse appears until a strobe edge arrives.
- R9: `strb_rst_n` (asynchronous, active low) clears the held byte and the flag. If both resets are held and then released, no spurious transfer follows, and later strobes transfer normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst | input | 1 | Synchronous active-high reset, local domain |
| strb_rst_n | input | 1 | Asynchronous active-low reset, strobe domain |
| strb | input | 1 | Gated strobe from the source |
| strb_data | input | DATA_W | Byte from the source, valid at the active strobe edge |
| ser_out | output | 1 | Serial output, MSB first |
| byte_loaded | output | 1 | One-cycle pulse when a byte enters the shift register |

## Verification
The bench drives every strobe edge on a falling local clock edge and counts the local rising edges that follow it. It expects the pulse after exactly `SYNC_STAGES`+1 edges: two for the rising-edge instance with one stage, and three for the falling-edge instance with two stages. Bit 7 is due one cycle after the pulse, and each lower bit one cycle after that. The bench samples every result on the falling edge midway through the cycle in which it is due. After the eighth bit it checks for zeros, and it checks that the pulse is low on the cycles on either side of it.

// File: rtl/strb_ser_pkg.sv
package strb_ser_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } strobe_edge_e;

endpackage

// File: rtl/strb_capture.sv
module strb_capture
    import strb_ser_pkg::*;
#(
    parameter int           DATA_W   = 8,
    parameter strobe_edge_e CAP_EDGE = EDGE_RISE
) (
    input  logic              strb,
    input  logic              arst_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] held_word,
    output logic              flag
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              flag;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.word = data_in;
        cap_d.flag = ~cap_q.flag;
    end

    generate
        if (CAP_EDGE == EDGE_RISE) begin : g_rise
            always_ff @(posedge strb or negedge arst_n) begin
                if (!arst_n) cap_q <= '0;
                else         cap_q <= cap_d;
            end
        end else begin : g_fall
            always_ff @(negedge strb or negedge arst_n) begin
                if (!arst_n) cap_q <= '0;
                else         cap_q <= cap_d;
            end
        end
    endgenerate

    assign held_word = cap_q.word;
    assign flag      = cap_q.flag;

endmodule

// File: rtl/flag_edge_sync.sv
module flag_edge_sync #(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_async,
    output logic load_pulse
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   dly;
        logic                   pulse;
    } sync_state_t;

    sync_state_t sy_d, sy_q;
    logic [SYNC_STAGES-1:0] chain_nx;
    logic                   synced;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            assign chain_nx = flag_async;
        end else begin : g_many
            assign chain_nx = {sy_q.chain[SYNC_STAGES-2:0], flag_async};
        end
    endgenerate

    assign synced = sy_q.chain[SYNC_STAGES-1];

    always_comb begin
        sy_d       = sy_q;
        sy_d.chain = chain_nx;
        sy_d.dly   = synced;
        sy_d.pulse = synced ^ sy_q.dly;
    end

    always_ff @(posedge clk) begin
        if (rst) sy_q <= '0;
        else     sy_q <= sy_d;
    end

    assign load_pulse = sy_q.pulse;

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    output logic [DATA_W-1:0] word
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } shf_state_t;

    shf_state_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) sh_d.word = load_word;
        else      sh_d.word = {sh_q.word[DATA_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign word = sh_q.word;

endmodule

// File: rtl/strobe_byte_serializer.sv
module strobe_byte_serializer
    import strb_ser_pkg::*;
#(
    parameter int           DATA_W      = 8,
    parameter int           SYNC_STAGES = 1,
    parameter strobe_edge_e CAP_EDGE    = EDGE_RISE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_rst_n,
    input  logic              strb,
    input  logic [DATA_W-1:0] strb_data,
    output logic              ser_out,
    output logic              byte_loaded
);

    logic [DATA_W-1:0] held_word;
    logic              xfer_flag;
    logic              load_pulse;
    logic [DATA_W-1:0] sh_word;

    strb_capture #(
        .DATA_W   (DATA_W),
        .CAP_EDGE (CAP_EDGE)
    ) u_capture (
        .strb      (strb),
        .arst_n    (strb_rst_n),
        .data_in   (strb_data),
        .held_word (held_word),
        .flag      (xfer_flag)
    );

    flag_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst        (rst),
        .flag_async (xfer_flag),
        .load_pulse (load_pulse)
    );

    ser_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load_pulse),
        .load_word (held_word),
        .word      (sh_word)
    );

    assign ser_out     = sh_word[DATA_W-1];
    assign byte_loaded = load_pulse;

endmodule

// File: rtl/strobe_byte_serializer_chk.sv
module strobe_byte_serializer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_loaded,
    input logic              ser_out,
    input logic [DATA_W-1:0] word
);

    localparam int AW = $clog2(DATA_W + 2);

    logic [AW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)                        age_q <= AW'(DATA_W);
        else if (byte_loaded)           age_q <= '0;
        else if (age_q < AW'(DATA_W))   age_q <= age_q + 1'b1;
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        byte_loaded |=> !byte_loaded); // R3

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(byte_loaded)) |-> (word == {$past(word[DATA_W-2:0]), 1'b0})); // R5

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (age_q >= AW'(DATA_W)) |-> !ser_out); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!byte_loaded && (word == '0))); // R8

endmodule

bind strobe_byte_serializer strobe_byte_serializer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .byte_loaded (byte_loaded),
    .ser_out     (ser_out),
    .word        (sh_word)
);

// File: tb/strobe_byte_serializer_test.sv
`timescale 1ns/1ps
module strobe_byte_serializer_test;
    import strb_ser_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strb_rst_n = 1'b0;
    logic       strb_r = 1'b0;
    logic       strb_f = 1'b0;
    logic [7:0] din = 8'h00;
    logic       ser_r, bl_r, ser_f, bl_f;

    int errors = 0;
    int checks = 0;
    int cnt_r  = 0;
    int cnt_f  = 0;

    always #10 clk = ~clk;

    strobe_byte_serializer #(.DATA_W(8), .SYNC_STAGES(1), .CAP_EDGE(EDGE_RISE)) uut (
        .clk(clk), .rst(rst), .strb_rst_n(strb_rst_n), .strb(strb_r),
        .strb_data(din), .ser_out(ser_r), .byte_loaded(bl_r));

    strobe_byte_serializer #(.DATA_W(8), .SYNC_STAGES(2), .CAP_EDGE(EDGE_FALL)) uut_fall (
        .clk(clk), .rst(rst), .strb_rst_n(strb_rst_n), .strb(strb_f),
        .strb_data(din), .ser_out(ser_f), .byte_loaded(bl_f));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [7:0] b, input int i);
        return (i < 8) ? b[7-i] : 1'b0;
    endfunction

    // Sends one byte to one instance, then follows its pulse and nbits serial bits.
    task automatic send(input bit fall, input logic [7:0] b, input int nbits);
        int lat;
        logic s, l;
        lat = fall ? 3 : 2;
        din = b;
        @(negedge clk);
        if (fall) strb_f = 1'b1; else strb_r = 1'b1;
        if (fall) begin
            @(negedge clk);
            strb_f = 1'b0;
            cnt_f++;
        end else begin
            cnt_r++;
        end
        for (int k = 1; k <= lat + nbits; k++) begin
            @(negedge clk);
            if (k == 1 && !fall) strb_r = 1'b0;
            s = fall ? ser_f : ser_r;
            l = fall ? bl_f : bl_r;
            if (k < lat)       chk(l == 1'b0, "R4 early pulse", l, 0);
            else if (k == lat) chk(l == 1'b1, "R4 pulse latency", l, 1);
            else begin
                chk(l == 1'b0, "R3 pulse width", l, 0);
                chk(s == exp_bit(b, k - lat - 1),
                    (k - lat - 1 < 8) ? "R5 serial bit" : "R6 zero fill",
                    s, exp_bit(b, k - lat - 1));
            end
        end
    endtask

    task automatic idle_check(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(bl_r == 1'b0 && bl_f == 1'b0, req, {bl_r, bl_f}, 0);
            chk(ser_r == 1'b0 && ser_f == 1'b0, req, {ser_r, ser_f}, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        strb_rst_n = 1'b1;
        idle_check(2, "R8 reset state");
        rst = 1'b0;
        idle_check(5, "R8 no pulse after reset");

        // R1: directed patterns on the rising-edge instance
        send(1'b0, 8'hA5, 10);
        send(1'b0, 8'h80, 10);
        send(1'b0, 8'h01, 10);
        send(1'b0, 8'hFF, 10);        // R6 zeros after all-ones
        // R7: reload while the previous byte is still shifting
        send(1'b0, 8'h3C, 3);
        send(1'b0, 8'hC3, 10);

        // R2: falling-edge instance with two synchronizer stages
        send(1'b1, 8'h5A, 10);
        send(1'b1, 8'hFF, 10);
        send(1'b1, 8'h96, 2);         // R7 truncated by next load
        send(1'b1, 8'h69, 10);

        for (int n = 0; n < 24; n++) begin
            logic [7:0] rb;
            int nb;
            rb = 8'($urandom);
            nb = ($urandom % 4 == 0) ? 1 + int'($urandom % 8) : 10;
            send(1'($urandom % 2), rb, nb);
        end
        repeat (12) @(negedge clk);

        // R9: leave both flags set, then reset both domains together
        if (cnt_r % 2 == 0) send(1'b0, 8'h11, 10);
        if (cnt_f % 2 == 0) send(1'b1, 8'h22, 10);
        @(negedge clk);
        rst = 1'b1;
        strb_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        strb_rst_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle_check(6, "R9 no spurious transfer");
        send(1'b0, 8'hE7, 10);        // R9 normal transfer after reset
        send(1'b1, 8'h7E, 10);        // R9

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule